// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital side of a 10-bit successive-approximation converter. It derives a conversion clock from the system clock using one of eight divisors and holds the track signal of the sample-and-hold for a programmable number of conversion-clock periods. It then spends twelve conversion-clock periods resolving the code. During that phase it presents trial codes to the DAC and reads back a single comparator bit. The analog parts (DAC, sample-and-hold, comparator) sit outside the block.

In single-shot mode, software raises `start`. The block runs one conversion, writes the code into a split result pair (upper eight bits and lower two bits) and sets a sticky interrupt flag. In threshold mode (`cmp_en` high), conversions repeat back to back. The result pair then holds a software-loaded threshold that conversions never overwrite. The flag is set only when a converted value is strictly greater than that threshold.

Top module: `sar_adc_seq`

## Requirements
- R1: `clk_sel` values 0..7 select conversion-clock divisors 2, 4, 6, 8, 12, 16, 24, 32. A single-shot conversion ends exactly (S+12)*D system-clock edges after the edge that accepts `start`, where D is the divisor and S the sample length.
- R2: `sample_o` stays high for S*D system cycles at the start of every conversion. S equals `samp_len`, except that values 0 and 1 are treated as 2.
- R3: The bit-decision phase follows the sample phase and lasts 12 conversion-clock periods. `sample_o` is low throughout this phase, and `dac_code` is 0 whenever the block is not in this phase.
- R4: Bits are resolved MSB first, one per conversion-clock period over the first ten periods. Each trial sets the bit under test in `dac_code`. `cmp_in`=1 (held input ≥ trial code) keeps the bit. The final code therefore equals the held input code.
- R5: At the end of a single-shot conversion, `res_hi` receives code bits 9..2 and `res_lo` receives bits 1..0.
- R6: Input changes after `sample_o` falls have no effect on the result.
- R7: The edge that accepts `start` (idle, `cmp_en`=0) raises `busy`. `busy` falls on the same edge that writes the result and sets `irq_flag`. A `start` pulse while `busy` is high is ignored and does not change the completion time.
- R8: With `cmp_en`=1, conversions repeat without a request. The result pair is not changed by them. `irq_flag` is set only when the converted code is greater than {`res_hi`,`res_lo``}`; an equal or smaller code leaves it clear.
- R9: The two modes exclude each other. `start` is ignored while `cmp_en`=1 (`busy` stays 0), and any change of `cmp_en` abandons a conversion in progress, returning to idle with `busy` low.
- R10: A `thr_wr` pulse loads `thr_val` into {`res_hi`,`res_lo`} on the next edge. A single-shot result written on the same edge takes priority.
- R11: `irq_flag` stays set until an `irq_clr` pulse clears it. A flag-setting event on the same edge wins.
- R12: After reset, `busy`, `irq_flag`, `sample_o`, `dac_code`, `res_hi` and `res_lo` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 3 | Conversion-clock divisor select |
| samp_len | input | 4 | Sample phase length in conversion-clock periods |
| cmp_en | input | 1 | Threshold (continuous) mode enable |
| start | input | 1 | Single-shot request pulse |
| thr_wr | input | 1 | Load result pair from thr_val |
| thr_val | input | 10 | Threshold / result write value |
| irq_clr | input | 1 | Clear interrupt flag |
| cmp_in | input | 1 | Comparator: held input ≥ dac_code |
| sample_o | output | 1 | Track command to the sample-and-hold |
| dac_code | output | 10 | Trial code to the DAC |
| busy | output | 1 | Single-shot conversion in progress |
| res_hi | output | 8 | Result / threshold bits 9..2 |
| res_lo | output | 2 | Result / threshold bits 1..0 |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with its default 10-bit resolution, 4-bit sample field and 12-period decision phase. This lets the behavioural sample-and-hold plus comparator model reproduce every code exactly. A vector table walks all eight divisors, including both clamped sample lengths and the all-ones and all-zeros codes. Each vector measures total conversion time and track-pulse width in system cycles. Directed runs then cover input changes after sampling, the threshold comparison at below, equal and above, and a mode change in mid-conversion.

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int RES_W      = 10,
  parameter int SEL_W      = 3,
  parameter int SAMP_W     = 4,
  parameter int CONV_TICKS = 12,
  parameter int MIN_SAMP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic [SAMP_W-1:0] samp_len,
  input  logic              cmp_en,
  input  logic              start,
  input  logic              thr_wr,
  input  logic [RES_W-1:0]  thr_val,
  input  logic              irq_clr,
  input  logic              cmp_in,
  output logic              sample_o,
  output logic [RES_W-1:0]  dac_code,
  output logic              busy,
  output logic [7:0]        res_hi,
  output logic [RES_W-9:0]  res_lo,
  output logic              irq_flag
);

  localparam int DIV_W = 6;
  localparam int PH_MAX = (CONV_TICKS > (1 << SAMP_W)) ? CONV_TICKS : (1 << SAMP_W);
  localparam int PH_W = $clog2(PH_MAX);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  typedef enum logic [1:0] {ST_IDLE, ST_SAMP, ST_CONV} state_t;

  state_t            state;
  logic [DIV_W-1:0]  div_cnt;
  logic [PH_W-1:0]   ph_cnt;
  logic [SEL_W-1:0]  sel_q;
  logic [SAMP_W-1:0] len_q;
  logic [RES_W-1:0]  sar;
  logic [RES_W-1:0]  res_q;
  logic              cmp_q;
  logic              go;
  logic              flag;

  function automatic logic [DIV_W-1:0] div_last(input logic [SEL_W-1:0] s);
    case (s)
      3'd0:    div_last = DIV_W'(1);
      3'd1:    div_last = DIV_W'(3);
      3'd2:    div_last = DIV_W'(5);
      3'd3:    div_last = DIV_W'(7);
      3'd4:    div_last = DIV_W'(11);
      3'd5:    div_last = DIV_W'(15);
      3'd6:    div_last = DIV_W'(23);
      default: div_last = DIV_W'(31);
    endcase
  endfunction

  logic            tick, abort, launch, go_set;
  logic            samp_end, bit_phase, conv_done;
  logic [PH_W-1:0] samp_ticks;
  logic [RES_W-1:0] trial;

  assign tick       = div_cnt == div_last(sel_q);
  assign abort      = cmp_en != cmp_q;
  assign launch     = state == ST_IDLE && !abort && (cmp_en || start);
  assign go_set     = launch && !cmp_en;
  assign samp_ticks = (PH_W'(len_q) < PH_W'(MIN_SAMP)) ? PH_W'(MIN_SAMP) : PH_W'(len_q);
  assign samp_end   = state == ST_SAMP && tick && ph_cnt == PH_W'(samp_ticks - 1'b1);
  assign bit_phase  = state == ST_CONV && ph_cnt < PH_W'(RES_W);
  assign conv_done  = state == ST_CONV && !abort && tick && ph_cnt == PH_W'(CONV_TICKS - 1);
  assign trial      = TOP_BIT >> ph_cnt;

  assign sample_o = state == ST_SAMP;
  assign dac_code = (state == ST_CONV) ? (sar | (bit_phase ? trial : '0)) : '0;
  assign busy     = go;
  assign res_hi   = res_q[RES_W-1 -: 8];
  assign res_lo   = res_q[RES_W-9:0];
  assign irq_flag = flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      div_cnt <= '0;
      ph_cnt  <= '0;
      sel_q   <= '0;
      len_q   <= '0;
      sar     <= '0;
      cmp_q   <= 1'b0;
    end else begin
      cmp_q <= cmp_en;
      if (abort) begin
        state   <= ST_IDLE;
        div_cnt <= '0;
        ph_cnt  <= '0;
      end else begin
        case (state)
          ST_IDLE: if (launch) begin
            state   <= ST_SAMP;
            div_cnt <= '0;
            ph_cnt  <= '0;
            sel_q   <= clk_sel;
            len_q   <= samp_len;
          end
          ST_SAMP: begin
            if (tick) begin
              div_cnt <= '0;
              if (samp_end) begin
                state  <= ST_CONV;
                ph_cnt <= '0;
                sar    <= '0;
              end else begin
                ph_cnt <= ph_cnt + 1'b1;
              end
            end else begin
              div_cnt <= div_cnt + 1'b1;
            end
          end
          ST_CONV: begin
            if (tick) begin
              div_cnt <= '0;
              if (bit_phase && cmp_in) sar <= sar | trial;
              if (conv_done) begin
                ph_cnt <= '0;
                if (cmp_en) begin
                  state <= ST_SAMP;
                  sel_q <= clk_sel;
                  len_q <= samp_len;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                ph_cnt <= ph_cnt + 1'b1;
              end
            end else begin
              div_cnt <= div_cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go    <= 1'b0;
      res_q <= '0;
      flag  <= 1'b0;
    end else begin
      if (abort || (conv_done && !cmp_en)) go <= 1'b0;
      else if (go_set)                     go <= 1'b1;

      if (conv_done && !cmp_en) res_q <= sar;
      else if (thr_wr)          res_q <= thr_val;

      if (conv_done && (!cmp_en || sar > res_q)) flag <= 1'b1;
      else if (irq_clr)                          flag <= 1'b0;
    end
  end

  p_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && !cmp_en && !cmp_q) |=> (busy && sample_o));

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !cmp_en) |=> (!busy && irq_flag));

  p_cmp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && $past(cmp_en) && !$past(thr_wr)) |-> $stable(res_q));

  p_min_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sample_o) && state == ST_CONV) |-> ($past(ph_cnt) >= PH_W'(MIN_SAMP - 1)));

  p_sar_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && !abort) |=> ($countones(sar ^ $past(sar)) <= 1));

  p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !conv_done) |=> !irq_flag);

  p_idle_dac_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (dac_code == '0));

endmodule

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb_top;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] clk_sel = '0;
  logic [3:0] samp_len = '0;
  logic       cmp_en = 1'b0, start = 1'b0, thr_wr = 1'b0, irq_clr = 1'b0;
  logic [9:0] thr_val = '0;
  logic       cmp_in;
  logic       sample_o, busy, irq_flag;
  logic [9:0] dac_code;
  logic [7:0] res_hi;
  logic [1:0] res_lo;

  logic [9:0] ain = '0;
  logic [9:0] held = '0;

  int n_chk = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) if (sample_o) held <= ain;
  always_comb cmp_in = held >= dac_code;

  sar_adc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .samp_len(samp_len),
    .cmp_en(cmp_en), .start(start), .thr_wr(thr_wr), .thr_val(thr_val),
    .irq_clr(irq_clr), .cmp_in(cmp_in), .sample_o(sample_o),
    .dac_code(dac_code), .busy(busy), .res_hi(res_hi), .res_lo(res_lo),
    .irq_flag(irq_flag)
  );

  // {sel, len, ain, expected divisor, expected sample periods}
  localparam logic [26:0] VEC [0:7] = '{
    {3'd0, 4'd2,  10'h3FF, 6'd2,  4'd2},
    {3'd1, 4'd0,  10'h000, 6'd4,  4'd2},
    {3'd2, 4'd5,  10'h155, 6'd6,  4'd5},
    {3'd3, 4'd1,  10'h2AA, 6'd8,  4'd2},
    {3'd4, 4'd3,  10'h200, 6'd12, 4'd3},
    {3'd5, 4'd15, 10'h1FF, 6'd16, 4'd15},
    {3'd6, 4'd2,  10'h001, 6'd24, 4'd2},
    {3'd7, 4'd4,  10'h123, 6'd32, 4'd4}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  // runs one single-shot conversion; optional input change and extra start after sampling
  task automatic convert(input logic [2:0] sel, input logic [3:0] len, input logic [9:0] a,
                         input logic disturb, output int cycles, output int scount);
    clk_sel = sel; samp_len = len; ain = a; start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    cycles = 0;
    scount = sample_o ? 1 : 0;
    while (!irq_flag && cycles < 2000) begin
      @(posedge clk);
      @(negedge clk);
      cycles++;
      if (sample_o) scount++;
      if (disturb && !sample_o && cycles == scount + 3) begin
        ain = ~a;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cycles, sc;
    cyc(3);
    // R12 reset state
    check(!busy && !irq_flag && !sample_o, "R12 flags", {busy, irq_flag, sample_o}, 0);
    check(dac_code == 0 && res_hi == 0 && res_lo == 0, "R12 regs", {res_hi, res_lo}, 0);
    rst_n = 1'b1;
    cyc(2);

    for (int v = 0; v < 8; v++) begin
      logic [2:0] sel; logic [3:0] len; logic [9:0] a; int d, s;
      {sel, len, a} = VEC[v][26:10];
      d = int'(VEC[v][9:4]);
      s = int'(VEC[v][3:0]);
      clear_flag();
      check(!irq_flag, "R11 clear", irq_flag, 0);
      convert(sel, len, a, 1'b0, cycles, sc);
      check(cycles == (s + 12) * d, "R1 total cycles", cycles, (s + 12) * d);
      check(sc == s * d, "R2 sample width", sc, s * d);
      check(res_hi == a[9:2], "R5 high part", res_hi, a[9:2]);
      check({res_hi, res_lo} == a, "R4 code", {res_hi, res_lo}, a);
      check(!busy && irq_flag, "R7 busy/flag at completion", {busy, irq_flag}, 1);
      check(dac_code == 0 && !sample_o, "R3 idle outputs", dac_code, 0);
    end

    // R6 input change after sampling, R7 start while busy ignored
    clear_flag();
    convert(3'd1, 4'd3, 10'h2C3, 1'b1, cycles, sc);
    check({res_hi, res_lo} == 10'h2C3, "R6 result unaffected", {res_hi, res_lo}, 10'h2C3);
    check(cycles == 15 * 4, "R7 start while busy ignored", cycles, 60);
    cyc(3);
    check(!busy, "R7 no second conversion", busy, 0);

    // R10 threshold load
    @(negedge clk) begin thr_val = 10'h200; thr_wr = 1'b1; end
    @(negedge clk) thr_wr = 1'b0;
    check({res_hi, res_lo} == 10'h200, "R10 threshold readback", {res_hi, res_lo}, 10'h200);

    // R8 / R9 threshold mode
    clk_sel = 3'd0; samp_len = 4'd2; ain = 10'h100;
    clear_flag();
    @(negedge clk) begin cmp_en = 1'b1; start = 1'b1; end
    @(negedge clk) start = 1'b0;
    cyc(100);
    check(!irq_flag, "R8 below threshold", irq_flag, 0);
    check(!busy, "R9 start ignored in threshold mode", busy, 0);
    check({res_hi, res_lo} == 10'h200, "R8 result pair kept", {res_hi, res_lo}, 10'h200);
    ain = 10'h200;
    cyc(100);
    check(!irq_flag, "R8 equal not flagged", irq_flag, 0);
    ain = 10'h201;
    cyc(100);
    check(irq_flag, "R8 above threshold", irq_flag, 1);
    check({res_hi, res_lo} == 10'h200, "R8 result pair kept after flag", {res_hi, res_lo}, 10'h200);
    @(negedge clk) cmp_en = 1'b0;
    cyc(3);
    check(!sample_o && dac_code == 0, "R9 leaving threshold mode stops", sample_o, 0);
    clear_flag();
    cyc(100);
    check(!irq_flag, "R11 flag stays clear", irq_flag, 0);

    // R9 mode change abandons single-shot
    clk_sel = 3'd2; samp_len = 4'd4; ain = 10'h0AB;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc(40);
    check(busy, "R7 busy during conversion", busy, 1);
    @(negedge clk) cmp_en = 1'b1;
    @(negedge clk) cmp_en = 1'b0;
    cyc(3);
    check(!busy && !sample_o, "R9 abandoned", busy, 0);
    cyc(200);
    check(!irq_flag, "R9 no completion after abandon", irq_flag, 0);
    check({res_hi, res_lo} == 10'h200, "R9 result untouched", {res_hi, res_lo}, 10'h200);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule